// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block is the read-side controller of a memory device that serves either plain asynchronous reads or synchronous burst reads. A single 16-bit configuration word, written through a simple write strobe and readable at any time, selects the mode and tunes every timing aspect of a burst. In burst mode the engine captures a start address when the address-valid strobe is high, counts a programmed number of clock edges, and then streams one word per cycle from an internal array model.

A burst can run for a fixed count of 8, 16 or 32 words or continue for as long as chip enable stays high. A fixed burst can wrap inside its aligned block. An optional one-cycle penalty is added when a linear burst crosses a 16-word boundary. A ready output qualifies the data stream. Both its polarity and its lead time relative to the data are set from the configuration word.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration word reads 16'hEFC8: asynchronous mode (bit 15=1), boundary penalty on (bit 14=1), latency code 5 (bits 13:11), ready active high (bit 10=1), ready with data (bit 8=1), wrap on (bit 3=1), continuous length (bits 2:0=000), with bits 9, 7 and 6 set. A write with `cfg_we` replaces the word on the next edge.
- R2: When bit 15 is 1, the address strobe has no effect. At every edge where `ce` is high, `data_out` takes the word at `addr_in` and `data_valid` goes high. The word stored at address a is the low 16 bits of a XOR 16'hC3A5.
- R3: When bit 15 is 0, an edge with `ce` and `adv` both high latches `addr_in`. The first word appears at the Nth edge after that edge, with N = code + 2 for latency codes 0 to 5. A new strobe during a burst restarts it.
- R4: Latency codes 6 and 7 behave as code 5, so the first word comes 7 edges after the latch.
- R5: Length codes 2, 3 and 4 give bursts of exactly 8, 16 and 32 words. After the last word, `data_valid` drops on the next edge.
- R6: With bit 3 set and a fixed length, addresses step upward inside the block of that length aligned to it. After the last address of the block, the next address is the first address of the block.
- R7: Length code 0, and the reserved codes 1, 5, 6 and 7, give a continuous linear burst that stops only when `ce` falls. Addresses roll over at the top of the address space.
- R8: With bit 14 set, a linear or continuous burst whose next address is a multiple of 16 shows one cycle with `data_valid` low before that word. Wrapping bursts never pause.
- R9: Bit 10 sets the active level of `rdy`: 1 means high and 0 means low.
- R10: In burst mode, bit 8 = 1 makes `rdy` active in exactly the cycles where `data_valid` is high. Bit 8 = 0 makes `rdy` active in the cycle before each word instead, given that `ce` stays high and no new strobe arrives. In asynchronous mode, `rdy` follows `data_valid`.
- R11: An edge with `ce` low ends any burst or read at once, so `data_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_q | output | 16 | Current configuration word |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address-valid strobe that starts a burst |
| addr_in | input | 12 | Read or burst start address |
| data_out | output | 16 | Read data |
| data_valid | output | 1 | High in cycles where `data_out` holds a new word |
| rdy | output | 1 | Ready indication, with configurable polarity and lead |

## Verification
Each cycle, the bench's queue model predicts `data_valid`, `data_out` and `rdy`. A wrong latency count, stepped address, word counter or penalty flag therefore shows as a mismatch in the first cycle where the affected word should appear or vanish. This is at most one burst length plus seven edges after the strobe. A wrong configuration decode shows in the latency or length of the very next burst. A slip in ready lead time shows one cycle before the word concerned, because `rdy` is compared on its own in every cycle.

// File: rtl/bre_pkg.sv
package bre_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam int CFG_W     = 16;
    localparam int SEG_WORDS = 16;
    localparam int CNT_W     = 7;
    localparam int LAT_W     = 3;

    localparam logic [CFG_W-1:0] CFG_RESET   = 16'hEFC8;
    localparam logic [31:0]      PATTERN_KEY = 32'h5A5AC3A5;

    // bit positions inside the configuration word
    localparam int B_ASYNC   = 15;
    localparam int B_PENALTY = 14;
    localparam int B_LAT_HI  = 13;
    localparam int B_LAT_LO  = 11;
    localparam int B_RDY_POL = 10;
    localparam int B_RDY_TIM = 8;
    localparam int B_WRAP    = 3;
    localparam int B_LEN_HI  = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_STREAM
    } seq_state_e;

    typedef struct packed {
        logic             async_mode;
        logic             cross_pen;
        logic [LAT_W-1:0] lat_code;
        logic             rdy_high;
        logic             rdy_with_data;
        logic             wrap_en;
        logic [5:0]       burst_words;   // 0 = continuous
    } rd_cfg_t;

    function automatic logic [LAT_W-1:0] sanitize_latency(logic [LAT_W-1:0] code);
        return (code > 3'd5) ? 3'd5 : code;
    endfunction

    function automatic logic [5:0] burst_words_of(logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd2:    n = 6'd8;
            3'd3:    n = 6'd16;
            3'd4:    n = 6'd32;
            default: n = 6'd0;
        endcase
        return n;
    endfunction

    function automatic rd_cfg_t decode_cfg(logic [CFG_W-1:0] w);
        rd_cfg_t c;
        c.async_mode    = w[B_ASYNC];
        c.cross_pen     = w[B_PENALTY];
        c.lat_code      = sanitize_latency(w[B_LAT_HI:B_LAT_LO]);
        c.rdy_high      = w[B_RDY_POL];
        c.rdy_with_data = w[B_RDY_TIM];
        c.wrap_en       = w[B_WRAP];
        c.burst_words   = burst_words_of(w[B_LEN_HI:0]);
        return c;
    endfunction

    function automatic logic [31:0] array_word(logic [31:0] a);
        return a ^ PATTERN_KEY;
    endfunction

endpackage

// File: rtl/bre_cfg_reg.sv
module bre_cfg_reg
    import bre_pkg::*;
#(
    parameter int              W         = CFG_W,
    parameter logic [W-1:0]    RESET_VAL = CFG_RESET
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] word_q,
    output rd_cfg_t      cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= RESET_VAL;
        end else if (we) begin
            word_q <= wdata;
        end
    end

    assign cfg = decode_cfg(word_q);

    AST_CFG_DEFAULT: assert property (@(posedge clk)
        rst |=> (word_q == RESET_VAL)); // R1

endmodule

// File: rtl/bre_latency_cnt.sv
module bre_latency_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_LAT_DESCEND: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/bre_addr_step.sv
module bre_addr_step #(
    parameter int AW  = 12,
    parameter int SEG = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [5:0]    burst_words,
    input  logic          wrap_en,
    input  logic          cross_pen,
    input  logic          pen_taken,
    output logic [AW-1:0] nxt,
    output logic          need_pen,
    output logic          wrap_act
);

    localparam int SEG_LOG = $clog2(SEG);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        wrap_act = wrap_en && (burst_words != 6'd0);
        mask     = AW'(burst_words) - AW'(1);
        inc      = cur + AW'(1);
        nxt      = wrap_act ? ((cur & ~mask) | (inc & mask)) : inc;
        need_pen = cross_pen && !wrap_act && !pen_taken
                   && (nxt[SEG_LOG-1:0] == '0);
    end

endmodule

// File: rtl/bre_ready_gen.sv
module bre_ready_gen (
    input  logic async_mode,
    input  logic rdy_high,
    input  logic rdy_with_data,
    input  logic ce,
    input  logic dv,
    input  logic will_present,
    output logic rdy_pin
);

    logic active;

    always_comb begin
        if (async_mode || rdy_with_data) begin
            active = dv;
        end else begin
            active = will_present && ce;
        end
        rdy_pin = rdy_high ? active : !active;
    end

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
    import bre_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int CW  = CFG_W,
    parameter int SEG = SEG_WORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] cfg_q,
    input  logic          ce,
    input  logic          adv,
    input  logic [AW-1:0] addr_in,
    output logic [DW-1:0] data_out,
    output logic          data_valid,
    output logic          rdy
);

    rd_cfg_t          cfg;
    seq_state_e       state_q;
    logic [AW-1:0]    cur_q;
    logic [AW-1:0]    start_q;
    logic [AW-1:0]    nxt_addr;
    logic [CNT_W-1:0] words_q;
    logic             pen_q;
    logic             dv_q;
    logic [DW-1:0]    dout_q;
    logic             sync_go;
    logic             lat_load;
    logic             lat_clr;
    logic             lat_expired;
    logic             need_pen;
    logic             wrap_act;
    logic             burst_done;
    logic             will_present;
    logic [AW-1:0]    wrap_mask;

    bre_cfg_reg #(.W(CW), .RESET_VAL(CFG_RESET)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .word_q (cfg_q),
        .cfg    (cfg)
    );

    assign sync_go  = ce && !cfg.async_mode;
    assign lat_load = sync_go && adv;
    assign lat_clr  = !sync_go;

    bre_latency_cnt #(.CW(LAT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .clr      (lat_clr),
        .load     (lat_load),
        .load_val (cfg.lat_code + 3'd1),
        .expired  (lat_expired)
    );

    bre_addr_step #(.AW(AW), .SEG(SEG)) u_step (
        .cur         (cur_q),
        .burst_words (cfg.burst_words),
        .wrap_en     (cfg.wrap_en),
        .cross_pen   (cfg.cross_pen),
        .pen_taken   (pen_q),
        .nxt         (nxt_addr),
        .need_pen    (need_pen),
        .wrap_act    (wrap_act)
    );

    assign burst_done = (cfg.burst_words != 6'd0)
                        && (words_q == CNT_W'(cfg.burst_words));

    assign will_present = sync_go && !adv
        && (((state_q == SEQ_WAIT) && lat_expired)
         || ((state_q == SEQ_STREAM) && !burst_done && !need_pen));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            start_q <= '0;
            words_q <= '0;
            pen_q   <= 1'b0;
            dv_q    <= 1'b0;
            dout_q  <= '0;
        end else if (!ce) begin
            state_q <= SEQ_IDLE;
            pen_q   <= 1'b0;
            dv_q    <= 1'b0;
        end else if (cfg.async_mode) begin
            state_q <= SEQ_IDLE;
            pen_q   <= 1'b0;
            dv_q    <= 1'b1;
            dout_q  <= DW'(array_word(32'(addr_in)));
        end else if (adv) begin
            state_q <= SEQ_WAIT;
            cur_q   <= addr_in;
            start_q <= addr_in;
            words_q <= '0;
            pen_q   <= 1'b0;
            dv_q    <= 1'b0;
        end else begin
            case (state_q)
                SEQ_WAIT: begin
                    if (lat_expired) begin
                        dout_q  <= DW'(array_word(32'(cur_q)));
                        dv_q    <= 1'b1;
                        words_q <= CNT_W'(1);
                        state_q <= SEQ_STREAM;
                    end else begin
                        dv_q <= 1'b0;
                    end
                end
                SEQ_STREAM: begin
                    if (burst_done) begin
                        state_q <= SEQ_IDLE;
                        dv_q    <= 1'b0;
                    end else if (need_pen) begin
                        pen_q <= 1'b1;
                        dv_q  <= 1'b0;
                    end else begin
                        cur_q  <= nxt_addr;
                        dout_q <= DW'(array_word(32'(nxt_addr)));
                        dv_q   <= 1'b1;
                        pen_q  <= 1'b0;
                        if (cfg.burst_words != 6'd0) begin
                            words_q <= words_q + 1'b1;
                        end
                    end
                end
                default: begin
                    dv_q <= 1'b0;
                end
            endcase
        end
    end

    bre_ready_gen u_rdy (
        .async_mode    (cfg.async_mode),
        .rdy_high      (cfg.rdy_high),
        .rdy_with_data (cfg.rdy_with_data),
        .ce            (ce),
        .dv            (dv_q),
        .will_present  (will_present),
        .rdy_pin       (rdy)
    );

    assign data_out   = dout_q;
    assign data_valid = dv_q;
    assign wrap_mask  = AW'(cfg.burst_words) - AW'(1);

    AST_ASYNC_READ: assert property (@(posedge clk) disable iff (rst)
        (ce && cfg.async_mode) |=> dv_q); // R2

    AST_FIXED_LEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_STREAM && cfg.burst_words != 6'd0)
            |-> (words_q <= CNT_W'(cfg.burst_words))); // R5

    AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_STREAM && wrap_act)
            |-> (((cur_q ^ start_q) & ~wrap_mask) == '0)); // R6

    AST_LEAD_READY: assert property (@(posedge clk) disable iff (rst)
        (!cfg.async_mode && !cfg.rdy_with_data && (rdy == cfg.rdy_high)
         && ce && !adv && !cfg_we) |=> dv_q); // R10

    AST_CE_ABORT: assert property (@(posedge clk) disable iff (rst)
        !ce |=> !dv_q); // R11

endmodule

// File: tb/tb_burst_read_engine.sv
module tb_burst_read_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic        ce = 1'b0;
    logic        adv = 1'b0;
    logic [11:0] addr_in = '0;
    logic [15:0] data_out;
    logic        data_valid;
    logic        rdy;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    check_on = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] m_cfg = 16'hEFC8;
    bit          q_v[$];
    logic [15:0] q_d[$];
    bit          e_v = 1'b0;
    logic [15:0] e_d = '0;

    always #10 clk = !clk;   // 50 MHz

    burst_read_engine dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_q      (cfg_q),
        .ce         (ce),
        .adv        (adv),
        .addr_in    (addr_in),
        .data_out   (data_out),
        .data_valid (data_valid),
        .rdy        (rdy)
    );

    function automatic logic [15:0] pat(logic [11:0] a);
        return {4'h0, a} ^ 16'hC3A5;   // R2 array contents
    endfunction

    function automatic logic [15:0] mk(bit asy, bit pen, int lat, bit pol,
                                       bit withd, bit wrap, int len);
        logic [15:0] w;
        w        = 16'h02C0;
        w[15]    = asy;
        w[14]    = pen;
        w[13:11] = lat[2:0];
        w[10]    = pol;
        w[8]     = withd;
        w[3]     = wrap;
        w[2:0]   = len[2:0];
        return w;
    endfunction

    task automatic build_queue(logic [11:0] start);
        int lat_n;
        int blen;
        bit wrapping;
        int count;
        logic [11:0] a;
        lat_n = (m_cfg[13:11] > 3'd5) ? 7 : int'(m_cfg[13:11]) + 2;
        case (m_cfg[2:0])
            3'd2: blen = 8;
            3'd3: blen = 16;
            3'd4: blen = 32;
            default: blen = 0;
        endcase
        wrapping = m_cfg[3] && (blen != 0);
        count = (blen != 0) ? blen : 80;
        q_v.delete();
        q_d.delete();
        for (int i = 0; i < lat_n - 1; i++) begin
            q_v.push_back(1'b0);
            q_d.push_back('0);
        end
        a = start;
        for (int i = 0; i < count; i++) begin
            if (i > 0) begin
                if (wrapping)
                    a = (a / 12'(blen)) * 12'(blen) + ((a + 12'd1) % 12'(blen));
                else
                    a = a + 12'd1;
                if (m_cfg[14] && !wrapping && (a % 12'd16 == 12'd0)) begin
                    q_v.push_back(1'b0);
                    q_d.push_back('0);
                end
            end
            q_v.push_back(1'b1);
            q_d.push_back(pat(a));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cfg = 16'hEFC8;
            q_v.delete();
            q_d.delete();
            e_v = 1'b0;
        end else begin
            if (!ce) begin
                q_v.delete();
                q_d.delete();
                e_v = 1'b0;
            end else if (m_cfg[15]) begin
                q_v.delete();
                q_d.delete();
                e_v = 1'b1;
                e_d = pat(addr_in);
            end else if (adv) begin
                e_v = 1'b0;
                build_queue(addr_in);
            end else if (q_v.size() > 0) begin
                logic [15:0] d;
                e_v = q_v.pop_front();
                d = q_d.pop_front();
                if (e_v) e_d = d;
            end else begin
                e_v = 1'b0;
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired (%s) actual=%0d expected=<150000", cur_req, cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // comparison in mid-cycle, away from the rising edge
    always @(negedge clk) begin
        #5;
        if (check_on) begin
            bit act;
            bit e_rdy;
            if (m_cfg[15] || m_cfg[8])
                act = e_v;
            else
                act = ce && !adv && (q_v.size() > 0) && q_v[0];
            e_rdy = m_cfg[10] ? act : !act;
            checks++;
            if (cfg_q !== m_cfg) begin
                failures++;
                $display("FAIL R1 cfg_q actual=%h expected=%h", cfg_q, m_cfg);
            end
            checks++;
            if (data_valid !== e_v) begin
                failures++;
                $display("FAIL %s data_valid actual=%b expected=%b t=%0t", cur_req, data_valid, e_v, $time);
            end
            if (e_v) begin
                checks++;
                if (data_out !== e_d) begin
                    failures++;
                    $display("FAIL %s data_out actual=%h expected=%h t=%0t", cur_req, data_out, e_d, $time);
                end
            end
            checks++;
            if (rdy !== e_rdy) begin
                failures++;
                $display("FAIL %s rdy (R9/R10 rule) actual=%b expected=%b t=%0t", cur_req, rdy, e_rdy, $time);
            end
        end
    end

    task automatic write_cfg(logic [15:0] w);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic burst(logic [11:0] a, int hold);
        ce = 1'b1;
        adv = 1'b1;
        addr_in = a;
        @(negedge clk);
        adv = 1'b0;
        addr_in = ~a;
        repeat (hold) @(negedge clk);
        ce = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset value, checked against the literal word
        checks++;
        if (cfg_q !== 16'hEFC8) begin
            failures++;
            $display("FAIL R1 reset cfg_q actual=%h expected=%h", cfg_q, 16'hEFC8);
        end
        check_on = 1'b1;

        // R2: asynchronous reads, strobe ignored
        cur_req = "R2";
        ce = 1'b1;
        for (int i = 0; i < 10; i++) begin
            addr_in = 12'(i * 371 + 5);
            adv = (i % 3 == 0);
            @(negedge clk);
        end
        adv = 1'b0;
        ce = 1'b0;
        repeat (2) @(negedge clk);

        // R3: every legal latency, linear 8-word burst
        cur_req = "R3";
        for (int lat = 0; lat < 6; lat++) begin
            write_cfg(mk(0, 0, lat, 1, 1, 0, 2));
            burst(12'h040 + 12'(lat), 20);
        end
        // R3: restart by a second strobe mid-burst
        write_cfg(mk(0, 0, 1, 1, 1, 0, 3));
        ce = 1'b1; adv = 1'b1; addr_in = 12'h300;
        @(negedge clk);
        adv = 1'b0;
        repeat (6) @(negedge clk);
        adv = 1'b1; addr_in = 12'h355;
        @(negedge clk);
        adv = 1'b0;
        repeat (24) @(negedge clk);
        ce = 1'b0;
        repeat (2) @(negedge clk);

        // R4: reserved latency codes
        cur_req = "R4";
        write_cfg(mk(0, 0, 6, 1, 1, 0, 2));
        burst(12'h081, 20);
        write_cfg(mk(0, 0, 7, 1, 1, 0, 2));
        burst(12'h0C2, 20);

        // R5: fixed lengths 16 and 32
        cur_req = "R5";
        write_cfg(mk(0, 0, 2, 1, 1, 0, 3));
        burst(12'h0A3, 30);
        write_cfg(mk(0, 0, 0, 1, 1, 0, 4));
        burst(12'h200, 42);

        // R6: wrap inside aligned block, penalty bit must not matter
        cur_req = "R6";
        write_cfg(mk(0, 0, 3, 1, 1, 1, 2));
        burst(12'h105, 20);
        write_cfg(mk(0, 1, 1, 1, 1, 1, 3));
        burst(12'h3FD, 28);
        write_cfg(mk(0, 1, 4, 1, 1, 1, 4));
        burst(12'h71E, 45);

        // R7: continuous, including reserved length codes and address rollover
        cur_req = "R7";
        write_cfg(mk(0, 0, 0, 1, 1, 1, 0));
        burst(12'hFF0, 40);
        write_cfg(mk(0, 0, 2, 1, 1, 0, 1));
        burst(12'h123, 30);
        write_cfg(mk(0, 0, 1, 1, 1, 0, 5));
        burst(12'h456, 25);

        // R8: boundary penalty in fixed linear and continuous bursts
        cur_req = "R8";
        write_cfg(mk(0, 1, 0, 1, 1, 0, 3));
        burst(12'h01C, 30);
        write_cfg(mk(0, 1, 2, 1, 1, 0, 0));
        burst(12'hFE9, 50);

        // R9: active-low ready
        cur_req = "R9";
        write_cfg(mk(0, 1, 1, 0, 1, 0, 2));
        burst(12'h00B, 20);

        // R10: ready one cycle ahead of data, around a penalty gap
        cur_req = "R10";
        write_cfg(mk(0, 1, 0, 1, 0, 0, 3));
        burst(12'h00D, 30);
        write_cfg(mk(0, 1, 3, 0, 0, 0, 0));
        burst(12'h1F6, 35);

        // R11: abort a fixed burst early, in wait and in stream
        cur_req = "R11";
        write_cfg(mk(0, 0, 5, 1, 0, 0, 4));
        burst(12'h400, 3);
        burst(12'h400, 15);

        // R2: back to asynchronous mode by a write
        cur_req = "R2";
        write_cfg(mk(1, 1, 5, 1, 1, 1, 0));
        ce = 1'b1;
        for (int i = 0; i < 6; i++) begin
            addr_in = 12'(i * 1000 + 77);
            @(negedge clk);
        end
        ce = 1'b0;
        repeat (3) @(negedge clk);

        check_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule